// File: doc/BRIEF.md
# GPIO Edge Capture and Interrupt Combiner

This block watches a wide set of general-purpose pins, grouped in banks of 32, and latches a per-pin event flag whenever an input pin makes a transition that software has armed: a low-to-high change for pins with their rising arm bit set, a high-to-low change for pins with their falling arm bit set. Pins that the direction mask marks as outputs never raise a flag. Each flag stays set until software clears it by writing a one to its position through the clear port, which selects one bank per write.

The flags are folded into three level interrupts. Pin 0 and pin 1 each drive a private line, and every other pin shares a third line. All three are registered, so they follow the flags one clock later. Separately, while the processor reports that it is halted, any level change on an input pin in a fixed wake-capable set raises a one-cycle wake pulse. This pulse does not depend on the edge arm bits.

The block expects already-sampled pin levels. Register decode sits outside it: the flag vector is exported whole so that a read mux can return one bank.

Top module: `gpio_edge_irq`

## Requirements
- R1: While `rst` is high, and in the cycle that follows it, `status`, `irq_pin0`, `irq_pin1`, `irq_shared` and `wake_req` are all zero.
- R2: When an input pin (its `pin_dir` bit is 0, meaning input) goes from 0 to 1 and its `rise_en` bit is 1, its `status` bit reads 1 after the clock edge that first samples the new level.
- R3: When an input pin goes from 1 to 0 and its `fall_en` bit is 1, its `status` bit reads 1 after the clock edge that first samples the new level.
- R4: A pin whose `pin_dir` bit is 1 never sets its `status` bit. A transition whose direction is not armed leaves the bit unchanged.
- R5: When `clr_we` is 1, every bit of bank `clr_bank` (pins `clr_bank*32` to `clr_bank*32+31`) that has a 1 in `clr_data` is cleared at that clock edge. Bits of other banks are not affected.
- R6: If a qualifying edge and a clear for the same bit fall in the same cycle, the bit stays set.
- R7: A set `status` bit stays set, regardless of pin activity or arm bits, until a clear removes it.
- R8: `irq_pin0` equals `status[0]` and `irq_pin1` equals `status[1]`, each delayed by one clock.
- R9: `irq_shared` equals the OR of `status[NUM_PINS-1:2]`, delayed by one clock.
- R10: `wake_req` is 1 for one cycle after a clock edge at which `halted` is 1 and an input pin in the wake-capable set has changed level. The wake-capable set is given per bank as 0x8003FE1B for bank 0, 0x002001FC for bank 1, 0xEC080000 for bank 2 and 0x0012007F for bank 3. A pin outside the set, a pin set as an output, or a change while `halted` is 0 gives no pulse.
- R11: A pin that is already high while reset is applied does not produce a rising edge when reset is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pin_level | input | NUM_PINS | Sampled pin levels |
| pin_dir | input | NUM_PINS | 1 = output, 0 = input |
| rise_en | input | NUM_PINS | Arm low-to-high capture per pin |
| fall_en | input | NUM_PINS | Arm high-to-low capture per pin |
| halted | input | 1 | Processor is halted |
| clr_we | input | 1 | Clear strobe |
| clr_bank | input | BANK_SEL_W | Bank selected by the clear |
| clr_data | input | 32 | Ones clear the matching flags |
| status | output | NUM_PINS | Sticky edge flags |
| irq_pin0 | output | 1 | Interrupt for pin 0 |
| irq_pin1 | output | 1 | Interrupt for pin 1 |
| irq_shared | output | 1 | Interrupt for pins 2 and above |
| wake_req | output | 1 | One-cycle wake pulse |

## Verification
The properties assume `rst` is high from time zero for at least one edge, and that every input is stable around the active clock edge. The bench meets this by asserting reset at time zero and driving all inputs two time units after a rising edge. The sticky-flag property assumes that only a `clr_we` strobe can remove a flag, so the bench never lowers a flag by any other path. The wake property assumes that `halted` is a clean level; the bench holds it steady across each wake case.

// File: rtl/gpio_edge_pkg.sv
package gpio_edge_pkg;
  localparam int BANK_W = 32;

  // Fixed set of input pins that can wake a halted core, per bank.
  function automatic logic [BANK_W-1:0] wake_mask_of(input int bank);
    case (bank)
      0:       return 32'h8003_FE1B;
      1:       return 32'h0020_01FC;
      2:       return 32'hEC08_0000;
      3:       return 32'h0012_007F;
      default: return '0;
    endcase
  endfunction
endpackage

// File: rtl/gpio_edge_bank.sv
module gpio_edge_bank #(
  parameter int                    W         = 32,
  parameter logic [W-1:0]          WAKE_MASK = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] lvl,
  input  logic [W-1:0] dir,
  input  logic [W-1:0] rise_en,
  input  logic [W-1:0] fall_en,
  input  logic [W-1:0] clr_mask,
  output logic [W-1:0] flags,
  output logic         wake_hit
);
  logic [W-1:0] prev_q;
  logic [W-1:0] rise_ev, fall_ev, edge_ev;

  // Previous sample is loaded during reset too, so a pin held high
  // through reset is not seen as a new rising edge on release.
  always_ff @(posedge clk) prev_q <= lvl;

  always_comb begin
    rise_ev  = lvl & ~prev_q & rise_en & ~dir;
    fall_ev  = ~lvl & prev_q & fall_en & ~dir;
    edge_ev  = rise_ev | fall_ev;
    wake_hit = |((lvl ^ prev_q) & ~dir & WAKE_MASK);
  end

  // New edges take priority over a simultaneous clear.
  always_ff @(posedge clk) begin
    if (rst) flags <= '0;
    else     flags <= (flags & ~clr_mask) | edge_ev;
  end
endmodule

// File: rtl/gpio_irq_merge.sv
module gpio_irq_merge #(
  parameter int NUM_PINS = 128,
  parameter int NBANKS   = 4
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [NUM_PINS-1:0] flags,
  input  logic [NBANKS-1:0]   wake_hit,
  input  logic                halted,
  output logic                irq_pin0,
  output logic                irq_pin1,
  output logic                irq_shared,
  output logic                wake_req
);
  always_ff @(posedge clk) begin
    if (rst) begin
      irq_pin0   <= 1'b0;
      irq_pin1   <= 1'b0;
      irq_shared <= 1'b0;
      wake_req   <= 1'b0;
    end else begin
      irq_pin0   <= flags[0];
      irq_pin1   <= flags[1];
      irq_shared <= |flags[NUM_PINS-1:2];
      wake_req   <= halted & (|wake_hit);
    end
  end
endmodule

// File: rtl/gpio_edge_irq.sv
module gpio_edge_irq #(
  parameter int NBANKS     = 4,
  localparam int BANK_W    = gpio_edge_pkg::BANK_W,
  localparam int NUM_PINS  = NBANKS * BANK_W,
  localparam int BANK_SEL_W = (NBANKS > 1) ? $clog2(NBANKS) : 1
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [NUM_PINS-1:0]   pin_level,
  input  logic [NUM_PINS-1:0]   pin_dir,
  input  logic [NUM_PINS-1:0]   rise_en,
  input  logic [NUM_PINS-1:0]   fall_en,
  input  logic                  halted,
  input  logic                  clr_we,
  input  logic [BANK_SEL_W-1:0] clr_bank,
  input  logic [BANK_W-1:0]     clr_data,
  output logic [NUM_PINS-1:0]   status,
  output logic                  irq_pin0,
  output logic                  irq_pin1,
  output logic                  irq_shared,
  output logic                  wake_req
);
  logic [NBANKS-1:0] wake_hit;

  for (genvar b = 0; b < NBANKS; b++) begin : g_bank
    logic [BANK_W-1:0] clr_mask;
    assign clr_mask = (clr_we && (clr_bank == BANK_SEL_W'(b))) ? clr_data : '0;

    gpio_edge_bank #(
      .W        (BANK_W),
      .WAKE_MASK(gpio_edge_pkg::wake_mask_of(b))
    ) i_bank (
      .clk     (clk),
      .rst     (rst),
      .lvl     (pin_level[b*BANK_W +: BANK_W]),
      .dir     (pin_dir[b*BANK_W +: BANK_W]),
      .rise_en (rise_en[b*BANK_W +: BANK_W]),
      .fall_en (fall_en[b*BANK_W +: BANK_W]),
      .clr_mask(clr_mask),
      .flags   (status[b*BANK_W +: BANK_W]),
      .wake_hit(wake_hit[b])
    );
  end

  gpio_irq_merge #(
    .NUM_PINS(NUM_PINS),
    .NBANKS  (NBANKS)
  ) i_merge (
    .clk       (clk),
    .rst       (rst),
    .flags     (status),
    .wake_hit  (wake_hit),
    .halted    (halted),
    .irq_pin0  (irq_pin0),
    .irq_pin1  (irq_pin1),
    .irq_shared(irq_shared),
    .wake_req  (wake_req)
  );
endmodule

// File: rtl/gpio_edge_irq_chk.sv
module gpio_edge_irq_chk #(
  parameter int NUM_PINS = 128
) (
  input logic                clk,
  input logic                rst,
  input logic [NUM_PINS-1:0] pin_dir,
  input logic                halted,
  input logic                clr_we,
  input logic [NUM_PINS-1:0] status,
  input logic                irq_pin0,
  input logic                irq_pin1,
  input logic                irq_shared,
  input logic                wake_req
);
  assert_reset_quiet_R1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (status == '0 && !irq_pin0 && !irq_pin1 && !irq_shared && !wake_req));

  assert_output_no_flag_R4: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> ((status & ~$past(status) & $past(pin_dir)) == '0));

  assert_flag_sticky_R7: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(clr_we)) |-> (($past(status) & ~status) == '0));

  assert_irq0_lag_R8: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (irq_pin0 == $past(status[0])));

  assert_irq1_lag_R8: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (irq_pin1 == $past(status[1])));

  assert_shared_lag_R9: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (irq_shared == $past(|status[NUM_PINS-1:2])));

  assert_wake_halted_R10: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && wake_req) |-> $past(halted));
endmodule

bind gpio_edge_irq gpio_edge_irq_chk #(.NUM_PINS(NUM_PINS)) i_chk (
  .clk       (clk),
  .rst       (rst),
  .pin_dir   (pin_dir),
  .halted    (halted),
  .clr_we    (clr_we),
  .status    (status),
  .irq_pin0  (irq_pin0),
  .irq_pin1  (irq_pin1),
  .irq_shared(irq_shared),
  .wake_req  (wake_req)
);

// File: tb/test_gpio_edge_irq.sv
module test_gpio_edge_irq;
  localparam int NP = 128;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [NP-1:0] pin_level = '0;
  logic [NP-1:0] pin_dir   = '0;
  logic [NP-1:0] rise_en   = '0;
  logic [NP-1:0] fall_en   = '0;
  logic          halted    = 1'b0;
  logic          clr_we    = 1'b0;
  logic [1:0]    clr_bank  = '0;
  logic [31:0]   clr_data  = '0;
  logic [NP-1:0] status;
  logic          irq_pin0, irq_pin1, irq_shared, wake_req;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  gpio_edge_irq i_gpio_edge_irq (
    .clk(clk), .rst(rst), .pin_level(pin_level), .pin_dir(pin_dir),
    .rise_en(rise_en), .fall_en(fall_en), .halted(halted),
    .clr_we(clr_we), .clr_bank(clr_bank), .clr_data(clr_data),
    .status(status), .irq_pin0(irq_pin0), .irq_pin1(irq_pin1),
    .irq_shared(irq_shared), .wake_req(wake_req)
  );

  // Table entries: {pin level, direction, expected flags} for pins 7..0.
  // Arm bits stay fixed: rising on pins 3..0, falling on pins 7..4.
  localparam logic [23:0] VEC [9] = '{
    24'h00_00_00, 24'h01_00_01, 24'h03_02_01, 24'h13_02_01, 24'h03_02_11,
    24'h02_02_11, 24'h06_00_15, 24'h86_00_15, 24'h06_00_95
  };

  task automatic cyc();
    @(posedge clk);
    #2;
  endtask

  task automatic chk(input string req, input logic [NP-1:0] act, input logic [NP-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog actual running expected finished");
    finish_run();
  end

  initial begin
    // R1 and R11: pins high and armed through reset
    pin_level = '1;
    rise_en   = '1;
    repeat (3) cyc();
    chk("R1 status in reset", status, '0);
    chk("R1 irq/wake in reset", NP'({irq_pin0, irq_pin1, irq_shared, wake_req}), '0);
    rst = 1'b0;
    cyc();
    cyc();
    chk("R11 no edge after reset release", status, '0);
    pin_level = '0;
    rise_en   = '0;
    cyc();
    rst = 1'b1;
    cyc();
    rst = 1'b0;
    cyc();

    // R2 R3 R4 table walk
    rise_en[7:0] = 8'h0F;
    fall_en[7:0] = 8'hF0;
    foreach (VEC[i]) begin
      pin_level[7:0] = VEC[i][23:16];
      pin_dir[7:0]   = VEC[i][15:8];
      cyc();
      chk($sformatf("R2 R3 R4 vector %0d", i), status, NP'(VEC[i][7:0]));
    end
    cyc();
    chk("R8 irq_pin0 set", NP'(irq_pin0), NP'(1));
    chk("R8 irq_pin1 clear", NP'(irq_pin1), NP'(0));
    chk("R9 shared set", NP'(irq_shared), NP'(1));

    // R7 sticky
    rise_en = '0;
    fall_en = '0;
    pin_level[7:0] = 8'h00;
    repeat (5) cyc();
    chk("R7 flags held", status, NP'(8'h95));

    // R5 clear
    clr_we = 1'b1; clr_bank = 2'd0; clr_data = 32'h95;
    cyc();
    clr_we = 1'b0;
    chk("R5 bank0 cleared", status, '0);
    chk("R8 irq_pin0 lags clear", NP'(irq_pin0), NP'(1));
    cyc();
    chk("R8 irq_pin0 after clear", NP'(irq_pin0), NP'(0));
    chk("R9 shared after clear", NP'(irq_shared), NP'(0));

    // R9 top pin
    rise_en[127]   = 1'b1;
    pin_level[127] = 1'b1;
    cyc();
    chk("R2 pin127 flag", status, {1'b1, 127'b0});
    chk("R9 shared lags", NP'(irq_shared), NP'(0));
    cyc();
    chk("R9 shared from pin127", NP'(irq_shared), NP'(1));
    chk("R8 irq_pin0 unaffected", NP'(irq_pin0), NP'(0));

    // R5 bank isolation
    clr_we = 1'b1; clr_bank = 2'd0; clr_data = 32'hFFFF_FFFF;
    cyc();
    chk("R5 other bank kept", status, {1'b1, 127'b0});
    clr_bank = 2'd3; clr_data = 32'h8000_0000;
    cyc();
    clr_we = 1'b0;
    chk("R5 bank3 cleared", status, '0);

    // R6 edge wins over clear
    rise_en[1] = 1'b1;
    pin_level[1] = 1'b1;
    cyc();
    chk("R2 pin1 flag", status, NP'(2));
    pin_level[1] = 1'b0;
    cyc();
    pin_level[1] = 1'b1;
    clr_we = 1'b1; clr_bank = 2'd0; clr_data = 32'h2;
    cyc();
    clr_we = 1'b0;
    chk("R6 edge beats clear", status, NP'(2));
    cyc();
    chk("R8 irq_pin1 set", NP'(irq_pin1), NP'(1));
    clr_we = 1'b1;
    cyc();
    clr_we = 1'b0;
    chk("R5 pin1 cleared", status, '0);
    rise_en = '0;

    // R10 wake
    halted = 1'b1;
    pin_level[0] = 1'b1;
    cyc();
    chk("R10 wake pin0", NP'(wake_req), NP'(1));
    cyc();
    chk("R10 wake one cycle", NP'(wake_req), NP'(0));
    pin_level[2] = 1'b1;
    cyc();
    chk("R10 pin2 not wake-capable", NP'(wake_req), NP'(0));
    halted = 1'b0;
    pin_level[0] = 1'b0;
    cyc();
    chk("R10 not halted", NP'(wake_req), NP'(0));
    halted = 1'b1;
    pin_dir[0] = 1'b1;
    pin_level[0] = 1'b1;
    cyc();
    chk("R10 output pin", NP'(wake_req), NP'(0));
    pin_dir[0] = 1'b0;
    pin_level[95] = 1'b1;
    cyc();
    chk("R10 bank2 bit31", NP'(wake_req), NP'(1));
    pin_level[102] = 1'b1;
    cyc();
    chk("R10 bank3 bit6", NP'(wake_req), NP'(1));
    pin_level[32] = 1'b1;
    cyc();
    chk("R10 bank1 bit0 not capable", NP'(wake_req), NP'(0));
    chk("R4 no flags without arm", status, '0);

    finish_run();
  end
endmodule